// File: doc/BRIEF.md
# Serial Configuration Register Slave

This block is the configuration port of a data-converter core. An external master talks to it over a half-duplex serial link made of a chip select (`csb`, active low), a serial clock (`sclk`) and a data line. Every transaction opens with a 16-bit instruction word. The word holds a read/write flag, a two-bit length code and a 13-bit register address. One or more data bytes follow it. Register contents are presented as parallel outputs, which the converter's trim, clocking, output and test logic use.

The serial inputs are oversampled by the block clock `clk` through two-stage synchronizers. Edges of `sclk` are detected in the `clk` domain. Bits are taken on the rising edge of `sclk`. Read data changes only after the falling edge of `sclk`, or right after a byte boundary, so the master can sample it on the next rising edge. Read data either shares the data line (three-wire mode, with `sdio_oe` as the tristate enable) or leaves on a separate `sdo` pin (four-wire mode). Bit order can be switched between MSB-first and LSB-first at run time. A self-clearing soft reset restores the register file.

Top module: `cfg_serial_slave`

## Requirements
- R1: After `rst_n` is low, every parallel register output is zero and both output enables (`sdio_oe`, `sdo_oe`) are low.
- R2: In MSB-first mode the instruction is taken as R/W (1 = read), then length bits L1, L0, then address bits A12 down to A0. Data is taken MSB first. A completed write byte appears on the register's parallel output.
- R3: Bit 0 of the port-configuration register at address 0x000 selects LSB-first order. In that order the instruction arrives fully reversed (A0 first, R/W last), and data moves LSB first in both directions.
- R4: Length code 0, 1 or 2 transfers 1, 2 or 3 data bytes. Bits clocked after the last byte write nothing.
- R5: After each data byte the address steps down by one in MSB-first mode and up by one in LSB-first mode.
- R6: Length code 3 streams bytes until `csb` rises. When a byte has been transferred at the address held in the burst-end register (0x002, 8 bits, upper address bits zero), the next byte goes to the transaction's start address.
- R7: During the data phase of a read, register bits are driven on `sdio_o` with `sdio_oe` high (three-wire mode). The first bit is valid before the first data rising edge.
- R8: Bit 1 of register 0x000 selects four-wire mode. Read data then comes out on `sdo_o` with `sdo_oe` high, and `sdio_oe` stays low.
- R9: Raising `csb` abandons any partial instruction or byte without writing. The next transaction starts with a fresh instruction phase.
- R10: Writing 1 to bit 2 of register 0x000 is a soft reset. It returns every register to zero except the LSB-first bit, which takes bit 0 of the same byte. Bit 2 always reads back 0.
- R11: Addresses not listed in R3, R6, R10 and R12 read as zero, and writes to them change nothing.
- R12: The register map is as follows. 0x020..0x023 are 8-bit trim registers. 0x072 bits 1:0 hold the clock divisor. 0x074 bits 2:0 hold the output mode. 0x0C0 bits 7:6 hold the test mode and bits 3:0 the test pattern. Unused bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock that oversamples the serial port |
| rst_n | input | 1 | Asynchronous active-low reset |
| csb | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial clock from the master |
| sdio_i | input | 1 | Data line input |
| sdio_o | output | 1 | Data line output value (three-wire reads) |
| sdio_oe | output | 1 | Tristate enable for the data line |
| sdo_o | output | 1 | Separate read-data output (four-wire mode) |
| sdo_oe | output | 1 | Enable for `sdo_o` |
| trim_o | output | 8*TRIM_N | Trim registers, register 0x020 in bits 7:0 |
| clk_div_o | output | 2 | Clock divisor select |
| out_mode_o | output | 3 | Output mode select |
| test_mode_o | output | 2 | Test mode select |
| test_pat_o | output | 4 | Test pattern select |
| lsb_first_o | output | 1 | Current bit-order control |
| four_wire_o | output | 1 | Current four-wire control |

## Verification
The hardest situations to reach are those defined by where inside a bit stream something happens. Examples are `csb` rising seven bits into an instruction or five bits into a data byte, a stream that wraps from the burst-end address back to its start, and a mode bit that changes the ordering of the very next transaction. The bench drives the port one bit at a time through a task, so it can stop after any number of bits, chain any number of bytes, and switch its own bit order to follow the register it has just written. Expected register contents come from a model array that is updated with the address-stepping and wrap rules.

// File: rtl/cfg_serial_slave.sv
module cfg_serial_slave #(
  parameter int          TRIM_N      = 4,
  parameter logic [12:0] CFG_ADDR    = 13'h000,
  parameter logic [12:0] BEND_ADDR   = 13'h002,
  parameter logic [12:0] TRIM_BASE   = 13'h020,
  parameter logic [12:0] CLKDIV_ADDR = 13'h072,
  parameter logic [12:0] OMODE_ADDR  = 13'h074,
  parameter logic [12:0] TEST_ADDR   = 13'h0C0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  csb,
  input  logic                  sclk,
  input  logic                  sdio_i,
  output logic                  sdio_o,
  output logic                  sdio_oe,
  output logic                  sdo_o,
  output logic                  sdo_oe,
  output logic [TRIM_N*8-1:0]   trim_o,
  output logic [1:0]            clk_div_o,
  output logic [2:0]            out_mode_o,
  output logic [1:0]            test_mode_o,
  output logic [3:0]            test_pat_o,
  output logic                  lsb_first_o,
  output logic                  four_wire_o
);
  localparam int TIW = (TRIM_N > 1) ? $clog2(TRIM_N) : 1;
  localparam logic [12:0] TRIM_END = TRIM_BASE + 13'(TRIM_N);

  typedef enum logic [1:0] {PH_INS, PH_DAT, PH_END} phase_t;

  logic [1:0]  csb_s, sdi_s;
  logic [2:0]  sclk_s;
  phase_t      phase;
  logic [3:0]  cnt;
  logic [15:0] sh;
  logic        rw_q;
  logic [1:0]  wlen_q, left_q;
  logic [12:0] addr_q, start_q;
  logic [7:0]  rd_sh;

  logic        lsb_q, four_q;
  logic [7:0]  bend_q;
  logic [7:0]  trim_q [TRIM_N];
  logic [1:0]  clkdiv_q;
  logic [2:0]  omode_q;
  logic [1:0]  tmode_q;
  logic [3:0]  tpat_q;

  wire rise = sclk_s[1] & ~sclk_s[2];
  wire fall = ~sclk_s[1] & sclk_s[2];
  wire din  = sdi_s[1];

  wire [15:0] ins_nx = lsb_q ? {din, sh[15:1]} : {sh[14:0], din};
  wire [7:0]  dat_nx = lsb_q ? {din, sh[7:1]}  : {sh[6:0], din};

  wire [12:0] step = lsb_q ? addr_q + 13'd1 : addr_q - 13'd1;
  wire [12:0] nxt  = (wlen_q == 2'd3 && addr_q == {5'b0, bend_q}) ? start_q : step;

  function automatic logic in_trim(input logic [12:0] a);
    return (a >= TRIM_BASE) && (a < TRIM_END);
  endfunction

  function automatic logic [TIW-1:0] trim_idx(input logic [12:0] a);
    logic [12:0] off;
    off = a - TRIM_BASE;
    return off[TIW-1:0];
  endfunction

  function automatic logic [7:0] rdmux(input logic [12:0] a);
    if (a == CFG_ADDR)         return {6'b0, four_q, lsb_q};
    else if (a == BEND_ADDR)   return bend_q;
    else if (in_trim(a))       return trim_q[trim_idx(a)];
    else if (a == CLKDIV_ADDR) return {6'b0, clkdiv_q};
    else if (a == OMODE_ADDR)  return {5'b0, omode_q};
    else if (a == TEST_ADDR)   return {tmode_q, 2'b0, tpat_q};
    else                       return 8'h00;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csb_s    <= 2'b11;
      sclk_s   <= '0;
      sdi_s    <= '0;
      phase    <= PH_INS;
      cnt      <= '0;
      sh       <= '0;
      rw_q     <= 1'b0;
      wlen_q   <= '0;
      left_q   <= '0;
      addr_q   <= '0;
      start_q  <= '0;
      rd_sh    <= '0;
      lsb_q    <= 1'b0;
      four_q   <= 1'b0;
      bend_q   <= '0;
      clkdiv_q <= '0;
      omode_q  <= '0;
      tmode_q  <= '0;
      tpat_q   <= '0;
      for (int i = 0; i < TRIM_N; i++) trim_q[i] <= '0;
    end else begin
      csb_s  <= {csb_s[0], csb};
      sclk_s <= {sclk_s[1:0], sclk};
      sdi_s  <= {sdi_s[0], sdio_i};
      if (csb_s[1]) begin
        phase <= PH_INS;
        cnt   <= '0;
      end else if (rise) begin
        case (phase)
          PH_INS: begin
            sh <= ins_nx;
            if (cnt == 4'd15) begin
              rw_q    <= ins_nx[15];
              wlen_q  <= ins_nx[14:13];
              left_q  <= ins_nx[14:13];
              addr_q  <= ins_nx[12:0];
              start_q <= ins_nx[12:0];
              rd_sh   <= rdmux(ins_nx[12:0]);
              phase   <= PH_DAT;
              cnt     <= '0;
            end else begin
              cnt <= cnt + 4'd1;
            end
          end
          PH_DAT: begin
            sh <= {8'b0, dat_nx};
            if (cnt == 4'd7) begin
              if (!rw_q) begin
                if (addr_q == CFG_ADDR) begin
                  lsb_q <= dat_nx[0];
                  if (dat_nx[2]) begin
                    four_q   <= 1'b0;
                    bend_q   <= '0;
                    clkdiv_q <= '0;
                    omode_q  <= '0;
                    tmode_q  <= '0;
                    tpat_q   <= '0;
                    for (int i = 0; i < TRIM_N; i++) trim_q[i] <= '0;
                  end else begin
                    four_q <= dat_nx[1];
                  end
                end else if (addr_q == BEND_ADDR) begin
                  bend_q <= dat_nx;
                end else if (in_trim(addr_q)) begin
                  trim_q[trim_idx(addr_q)] <= dat_nx;
                end else if (addr_q == CLKDIV_ADDR) begin
                  clkdiv_q <= dat_nx[1:0];
                end else if (addr_q == OMODE_ADDR) begin
                  omode_q <= dat_nx[2:0];
                end else if (addr_q == TEST_ADDR) begin
                  tmode_q <= dat_nx[7:6];
                  tpat_q  <= dat_nx[3:0];
                end
              end
              addr_q <= nxt;
              rd_sh  <= rdmux(nxt);
              cnt    <= '0;
              if (wlen_q != 2'd3) begin
                if (left_q == 2'd0) phase <= PH_END;
                else left_q <= left_q - 2'd1;
              end
            end else begin
              cnt <= cnt + 4'd1;
            end
          end
          default: ;
        endcase
      end else if (fall && phase == PH_DAT && rw_q && cnt != 4'd0) begin
        rd_sh <= lsb_q ? {1'b0, rd_sh[7:1]} : {rd_sh[6:0], 1'b0};
      end
    end
  end

  wire rd_act = ~csb_s[1] & (phase == PH_DAT) & rw_q;
  wire bit_o  = lsb_q ? rd_sh[0] : rd_sh[7];

  assign sdio_o  = bit_o;
  assign sdo_o   = bit_o;
  assign sdio_oe = rd_act & ~four_q;
  assign sdo_oe  = rd_act & four_q;

  for (genvar g = 0; g < TRIM_N; g++) begin : g_trim
    assign trim_o[g*8 +: 8] = trim_q[g];
  end

  assign clk_div_o   = clkdiv_q;
  assign out_mode_o  = omode_q;
  assign test_mode_o = tmode_q;
  assign test_pat_o  = tpat_q;
  assign lsb_first_o = lsb_q;
  assign four_wire_o = four_q;
endmodule

// File: rtl/cfg_serial_slave_chk.sv
module cfg_serial_slave_chk #(
  parameter int TRIM_N = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                csb,
  input logic                sdio_oe,
  input logic                sdo_oe,
  input logic                four_wire_o,
  input logic                lsb_first_o,
  input logic [TRIM_N*8-1:0] trim_o,
  input logic [1:0]          clk_div_o,
  input logic [2:0]          out_mode_o,
  input logic [1:0]          test_mode_o,
  input logic [3:0]          test_pat_o
);
  assert_oe_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(sdio_oe && sdo_oe));

  assert_sdio_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    four_wire_o |-> !sdio_oe);

  assert_oe_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (csb && $past(csb) && $past(csb, 2)) |-> (!sdio_oe && !sdo_oe));

  assert_regs_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (csb && $past(csb) && $past(csb, 2)) |=>
      $stable({trim_o, clk_div_o, out_mode_o, test_mode_o, test_pat_o,
               lsb_first_o, four_wire_o}));

  assert_no_rd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (csb && $past(csb) && $past(csb, 2)) |=> $stable(lsb_first_o));
endmodule

bind cfg_serial_slave cfg_serial_slave_chk #(.TRIM_N(TRIM_N)) chk_i (
  .clk(clk), .rst_n(rst_n), .csb(csb), .sdio_oe(sdio_oe), .sdo_oe(sdo_oe),
  .four_wire_o(four_wire_o), .lsb_first_o(lsb_first_o), .trim_o(trim_o),
  .clk_div_o(clk_div_o), .out_mode_o(out_mode_o), .test_mode_o(test_mode_o),
  .test_pat_o(test_pat_o)
);

// File: tb/cfg_serial_slave_tb_top.sv
module cfg_serial_slave_tb_top;
  localparam int HALF = 8;
  localparam int TN = 4;

  logic clk = 1'b0, rst_n = 1'b0, csb = 1'b1, sclk = 1'b0, sdio_i = 1'b0;
  logic sdio_o, sdio_oe, sdo_o, sdo_oe, lsb_first_o, four_wire_o;
  logic [TN*8-1:0] trim_o;
  logic [1:0] clk_div_o, test_mode_o;
  logic [2:0] out_mode_o;
  logic [3:0] test_pat_o;

  int checks = 0, fails = 0;
  bit done = 0;
  bit tb_lsb = 0, four_mode = 0, rd_on = 0, oe_ok = 1;
  logic [7:0] exp_t [TN];
  logic [12:0] rsv [8];

  always #10 clk = ~clk;

  cfg_serial_slave #(.TRIM_N(TN)) dut_i (
    .clk(clk), .rst_n(rst_n), .csb(csb), .sclk(sclk), .sdio_i(sdio_i),
    .sdio_o(sdio_o), .sdio_oe(sdio_oe), .sdo_o(sdo_o), .sdo_oe(sdo_oe),
    .trim_o(trim_o), .clk_div_o(clk_div_o), .out_mode_o(out_mode_o),
    .test_mode_o(test_mode_o), .test_pat_o(test_pat_o),
    .lsb_first_o(lsb_first_o), .four_wire_o(four_wire_o));

  function automatic logic [TN*8-1:0] pack();
    logic [TN*8-1:0] v;
    for (int i = 0; i < TN; i++) v[i*8 +: 8] = exp_t[i];
    return v;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic bit_x(input logic d, output logic q);
    sdio_i = d;
    repeat (HALF) @(negedge clk);
    q = four_mode ? sdo_o : sdio_o;
    if (rd_on) oe_ok &= four_mode ? (sdo_oe && !sdio_oe) : (sdio_oe && !sdo_oe);
    sclk = 1'b1;
    repeat (HALF) @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic cs_lo();
    csb = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic cs_hi();
    csb = 1'b1;
    rd_on = 0;
    repeat (4*HALF) @(negedge clk);
  endtask

  task automatic instr(input logic rw, input logic [1:0] w, input logic [12:0] a);
    logic [15:0] word;
    logic q;
    word = {rw, w, a};
    for (int i = 0; i < 16; i++) bit_x(tb_lsb ? word[i] : word[15-i], q);
    rd_on = rw;
  endtask

  task automatic byte_x(input logic [7:0] wb, output logic [7:0] rb);
    logic q;
    for (int i = 0; i < 8; i++) begin
      int idx;
      idx = tb_lsb ? i : 7 - i;
      bit_x(wb[idx], q);
      rb[idx] = q;
    end
  endtask

  task automatic wr1(input logic [12:0] a, input logic [7:0] d);
    logic [7:0] x;
    cs_lo(); instr(1'b0, 2'd0, a); byte_x(d, x); cs_hi();
  endtask

  task automatic rd1(input logic [12:0] a, output logic [7:0] d);
    cs_lo(); instr(1'b1, 2'd0, a); byte_x(8'h00, d); cs_hi();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog act=0 exp=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, x;
    rsv[0] = 13'h001; rsv[1] = 13'h003; rsv[2] = 13'h01F; rsv[3] = 13'h024;
    rsv[4] = 13'h071; rsv[5] = 13'h073; rsv[6] = 13'h0C1; rsv[7] = 13'h1FFF;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk({trim_o, clk_div_o, out_mode_o, test_mode_o, test_pat_o, lsb_first_o,
         four_wire_o, sdio_oe, sdo_oe} == '0, "R1 reset", 32'(trim_o), 0);

    // R2/R7: write and read back each trim register MSB first
    for (int k = 0; k < TN; k++) begin
      exp_t[k] = 8'(8'h37 * (k + 1)) ^ 8'hA5;
      wr1(13'h020 + 13'(k), exp_t[k]);
    end
    chk(trim_o == pack(), "R2 parallel", trim_o, pack());
    for (int k = 0; k < TN; k++) begin
      oe_ok = 1;
      rd1(13'h020 + 13'(k), d);
      chk(d == exp_t[k] && oe_ok, "R7 readback", {oe_ok, d}, {1'b1, exp_t[k]});
    end

    // R11: reserved addresses
    for (int k = 0; k < 8; k++) begin
      wr1(rsv[k], 8'hFF);
      rd1(rsv[k], d);
      chk(d == 8'h00, "R11 reserved read", d, 0);
    end
    chk(trim_o == pack() && {clk_div_o, out_mode_o, test_mode_o, test_pat_o, four_wire_o, lsb_first_o} == '0,
        "R11 writes ignored", trim_o, pack());

    // R4/R5: three-byte write downward, extra byte dropped
    cs_lo(); instr(1'b0, 2'd2, 13'h023);
    byte_x(8'h31, x); byte_x(8'h32, x); byte_x(8'h33, x); byte_x(8'h34, x);
    cs_hi();
    exp_t[3] = 8'h31; exp_t[2] = 8'h32; exp_t[1] = 8'h33;
    chk(trim_o == pack(), "R4 R5 length and step", trim_o, pack());

    // R5/R7: two-byte read downward
    oe_ok = 1;
    cs_lo(); instr(1'b1, 2'd1, 13'h022); byte_x(0, d); byte_x(0, x); cs_hi();
    chk(d == 8'h32 && x == 8'h33 && oe_ok, "R5 read step", {oe_ok, d, x}, {1'b1, 16'h3233});

    // R12: register map and unused bits
    wr1(13'h072, 8'hFF); rd1(13'h072, d);
    chk(clk_div_o == 2'd3 && d == 8'h03, "R12 clkdiv", {clk_div_o, d}, {2'd3, 8'h03});
    wr1(13'h074, 8'hFF); rd1(13'h074, d);
    chk(out_mode_o == 3'd7 && d == 8'h07, "R12 outmode", {out_mode_o, d}, {3'd7, 8'h07});
    wr1(13'h0C0, 8'hFF); rd1(13'h0C0, d);
    chk(test_mode_o == 2'd3 && test_pat_o == 4'hF && d == 8'hCF, "R12 test", d, 8'hCF);

    // R6: streaming with burst-end wrap
    wr1(13'h002, 8'h21);
    cs_lo(); instr(1'b0, 2'd3, 13'h023);
    for (int k = 0; k < 5; k++) byte_x(8'h41 + 8'(k), x);
    cs_hi();
    exp_t[3] = 8'h44; exp_t[2] = 8'h45; exp_t[1] = 8'h43;
    chk(trim_o == pack(), "R6 stream write wrap", trim_o, pack());
    begin
      logic [31:0] got;
      cs_lo(); instr(1'b1, 2'd3, 13'h022);
      for (int k = 0; k < 4; k++) begin byte_x(0, d); got = {got[23:0], d}; end
      cs_hi();
      chk(got == 32'h45434543, "R6 stream read wrap", got, 32'h45434543);
    end

    // R9: abort mid-byte and mid-instruction
    cs_lo(); instr(1'b0, 2'd0, 13'h020);
    for (int k = 0; k < 5; k++) bit_x(1'b1, x[0]);
    cs_hi();
    chk(trim_o == pack(), "R9 partial byte", trim_o, pack());
    cs_lo();
    for (int k = 0; k < 7; k++) bit_x(1'b1, x[0]);
    cs_hi();
    wr1(13'h020, 8'h5A); exp_t[0] = 8'h5A;
    chk(trim_o == pack(), "R9 fresh instruction", trim_o, pack());

    // R3: LSB-first order, upward step
    wr1(13'h000, 8'h01); tb_lsb = 1;
    chk(lsb_first_o == 1'b1, "R3 order bit", lsb_first_o, 1);
    cs_lo(); instr(1'b0, 2'd1, 13'h020); byte_x(8'h61, x); byte_x(8'h62, x); cs_hi();
    exp_t[0] = 8'h61; exp_t[1] = 8'h62;
    chk(trim_o == pack(), "R3 R5 lsb write", trim_o, pack());
    rd1(13'h021, d);
    chk(d == 8'h62, "R3 lsb read", d, 8'h62);

    // R8: four-wire reads
    wr1(13'h000, 8'h03); four_mode = 1;
    chk(four_wire_o == 1'b1, "R8 mode bit", four_wire_o, 1);
    oe_ok = 1;
    cs_lo(); instr(1'b1, 2'd1, 13'h022); byte_x(0, d); byte_x(0, x); cs_hi();
    chk(d == 8'h45 && x == 8'h44 && oe_ok, "R8 sdo read", {oe_ok, d, x}, {1'b1, 16'h4544});

    // R10: soft reset keeps order bit only
    wr1(13'h000, 8'h07); four_mode = 0;
    for (int k = 0; k < TN; k++) exp_t[k] = 8'h00;
    chk(trim_o == '0 && {clk_div_o, out_mode_o, test_mode_o, test_pat_o, four_wire_o} == '0
        && lsb_first_o, "R10 soft reset", {trim_o[7:0], lsb_first_o}, 9'h001);
    rd1(13'h000, d);
    chk(d == 8'h01, "R10 self clear", d, 8'h01);
    rd1(13'h002, d);
    chk(d == 8'h00, "R10 burst end cleared", d, 0);

    // R2: back to MSB-first
    wr1(13'h000, 8'h00); tb_lsb = 0;
    wr1(13'h020, 8'h77); exp_t[0] = 8'h77;
    chk(trim_o == pack() && !lsb_first_o, "R2 msb restore", trim_o, pack());

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule